// File: doc/BRIEF.md
# Stencil Displacement Field Updater

This block advances a three-component displacement field by one explicit Euler step over a rectangular volume tile. Each input beat carries the displacement vector u and the velocity vector v of one voxel. Voxels arrive in raster order: x fastest, then y, then z. The block keeps a rolling store of three z-planes, so every voxel enters it exactly once.

For every voxel that has all six face neighbours inside the tile, the block does four things. It takes central-difference gradients of each displacement component. It subtracts the advection term (v·∇)u from v to get a rate. It adds the rate, scaled by a constant timestep, to the centre displacement. The result leaves the block on two output streams in the same cycle: one that feeds a memory writer and one that feeds a downstream consumer.

Boundary voxels produce no output, so an NX×NY×NZ tile yields (NX-2)×(NY-2)×(NZ-2) results. A new tile starts automatically after the last voxel of the previous one.

Top module: `disp_stencil_update`

## Requirements
- R1: Reset (active-low `rst_n`, synchronous) clears both output valids. It also returns the raster position to voxel (0,0,0) of a fresh tile, even when reset arrives partway through a tile.
- R2: An output is produced only for an accepted input voxel at (x,y,z) with z ≥ 2, 1 ≤ x ≤ NX-2 and 1 ≤ y ≤ NY-2. When that holds, `wr_valid` is high in the cycle after the accepting clock edge; otherwise it is low in that cycle.
- R3: The reported coordinates of a result are those of the stencil centre, (x, y, z-1), where (x,y,z) is the input voxel that completed the stencil.
- R4: Each gradient term is a central difference along its own axis: the +1 neighbour minus the -1 neighbour, formed in W+1 bits and arithmetic-shifted right by one (rounding toward minus infinity). Component c of the result uses the gradient of u component c.
- R5: With all values signed fixed point carrying FRAC=10 fraction bits, component c of the result is computed in three steps. First, adv = vx·∂x uc + vy·∂y uc + vz·∂z uc, kept exactly at 2·FRAC fraction bits. Second, r = (vc << FRAC) - adv. Third, the result is uc + ((DT·r + 2^(2·FRAC-1)) >>> 2·FRAC), truncated to W bits. DT is a constant parameter with FRAC fraction bits.
- R6: The forward stream (`fw_valid`, `fw_data`) matches the write stream (`wr_valid`, `wr_data`) in every cycle.
- R7: A cycle with `in_valid` low advances nothing. The cycle after it shows no output.
- R8: The three-plane store rotates, so that plane z overwrites plane z-3. A new tile begins after NX·NY·NZ accepted voxels, and its first result appears only once its own third plane is arriving.
- R9: Vectors are packed with component 1 (x) in bits [W-1:0], component 2 (y) in [2W-1:W] and component 3 (z) in [3W-1:2W], for `in_u`, `in_v`, `wr_data` and `fw_data` alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input voxel present this cycle |
| in_u | input | 3*W | Displacement vector of the input voxel |
| in_v | input | 3*W | Velocity vector of the input voxel |
| wr_valid | output | 1 | Write stream result valid |
| wr_x | output | XW | Result x coordinate |
| wr_y | output | YW | Result y coordinate |
| wr_z | output | ZW | Result z coordinate |
| wr_data | output | 3*W | Updated displacement vector |
| fw_valid | output | 1 | Forward stream result valid |
| fw_data | output | 3*W | Updated displacement vector for the consumer |

## Verification
Every result is due exactly one cycle after the clock edge that accepts the input voxel completing its stencil, because one register stage sits between the input and both streams. The bench drives each voxel just after an edge and samples the outputs 1 ns after the following edge. At that point it compares the valid flag, coordinates and data against a model of the arithmetic built from the tile arrays it generated. Idle cycles are inserted at random, and each one is followed by a check that no result appeared in the next cycle.

// File: rtl/disp_stencil_update.sv
module disp_stencil_update #(
  parameter int NX   = 8,
  parameter int NY   = 6,
  parameter int NZ   = 5,
  parameter int W    = 32,
  parameter int FRAC = 10,
  parameter int DT   = 256,
  parameter int XW   = $clog2(NX),
  parameter int YW   = $clog2(NY),
  parameter int ZW   = $clog2(NZ)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [3*W-1:0] in_u,
  input  logic [3*W-1:0] in_v,
  output logic           wr_valid,
  output logic [XW-1:0]  wr_x,
  output logic [YW-1:0]  wr_y,
  output logic [ZW-1:0]  wr_z,
  output logic [3*W-1:0] wr_data,
  output logic           fw_valid,
  output logic [3*W-1:0] fw_data
);
  localparam int NPL = NX * NY;
  localparam int IW  = $clog2(NPL);
  localparam int SW  = 2 * W + 3;
  localparam int TW  = SW + W;
  localparam logic [XW-1:0] XLAST = XW'(NX - 1);
  localparam logic [XW-1:0] XHI   = XW'(NX - 2);
  localparam logic [YW-1:0] YLAST = YW'(NY - 1);
  localparam logic [YW-1:0] YHI   = YW'(NY - 2);
  localparam logic [ZW-1:0] ZLAST = ZW'(NZ - 1);
  localparam logic [ZW-1:0] ZTWO  = ZW'(2);
  localparam logic signed [TW-1:0] HALF = TW'(1) <<< (2 * FRAC - 1);
  localparam logic signed [W-1:0]  DTV  = W'(DT);

  logic [W-1:0] ub [0:2][0:NPL-1][0:2];
  logic [W-1:0] vb [0:2][0:NPL-1][0:2];

  logic [XW-1:0] px;
  logic [YW-1:0] py;
  logic [ZW-1:0] pz;
  logic [1:0]    wp;
  logic [1:0]    pm, pmm;
  logic [IW-1:0] idx, ixm, ixp, iym, iyp;
  logic          hit;
  logic [3*W-1:0] nd;

  assign pm  = (wp == 2'd0) ? 2'd2 : wp - 2'd1;
  assign pmm = (wp == 2'd2) ? 2'd0 : wp + 2'd1;
  assign idx = IW'(py) * IW'(NX) + IW'(px);
  assign ixm = (px == '0)    ? idx : idx - IW'(1);
  assign ixp = (px == XLAST) ? idx : idx + IW'(1);
  assign iym = (py == '0)    ? idx : idx - IW'(NX);
  assign iyp = (py == YLAST) ? idx : idx + IW'(NX);
  assign hit = in_valid && pz >= ZTWO && px != '0 && px <= XHI && py != '0 && py <= YHI;

  function automatic logic signed [W:0] cdiff(input logic [W-1:0] hi, input logic [W-1:0] lo);
    logic signed [W:0] d;
    d = $signed({hi[W-1], hi}) - $signed({lo[W-1], lo});
    return d >>> 1;
  endfunction

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic signed [W:0]    gx, gy, gz;
    logic signed [SW-1:0] adv, rate;
    logic signed [TW-1:0] prod, rnd;
    logic signed [W-1:0]  uc, vc, vx, vy, vz;

    assign uc = $signed(ub[pm][idx][c]);
    assign vc = $signed(vb[pm][idx][c]);
    assign vx = $signed(vb[pm][idx][0]);
    assign vy = $signed(vb[pm][idx][1]);
    assign vz = $signed(vb[pm][idx][2]);
    assign gx = cdiff(ub[pm][ixp][c], ub[pm][ixm][c]);
    assign gy = cdiff(ub[pm][iyp][c], ub[pm][iym][c]);
    assign gz = cdiff(in_u[c*W +: W], ub[pmm][idx][c]);
    assign adv  = SW'(vx) * SW'(gx) + SW'(vy) * SW'(gy) + SW'(vz) * SW'(gz);
    assign rate = (SW'(vc) <<< FRAC) - adv;
    assign prod = TW'(rate) * TW'(DTV);
    assign rnd  = (prod + HALF) >>> (2 * FRAC);
    assign nd[c*W +: W] = W'(TW'(uc) + rnd);
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int c = 0; c < 3; c++) begin
        ub[wp][idx][c] <= in_u[c*W +: W];
        vb[wp][idx][c] <= in_v[c*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px <= '0;
      py <= '0;
      pz <= '0;
      wp <= 2'd0;
    end else if (in_valid) begin
      if (px == XLAST) begin
        px <= '0;
        if (py == YLAST) begin
          py <= '0;
          if (pz == ZLAST) begin
            pz <= '0;
            wp <= 2'd0;
          end else begin
            pz <= pz + ZW'(1);
            wp <= (wp == 2'd2) ? 2'd0 : wp + 2'd1;
          end
        end else begin
          py <= py + YW'(1);
        end
      end else begin
        px <= px + XW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_x     <= '0;
      wr_y     <= '0;
      wr_z     <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= hit;
      if (hit) begin
        wr_x    <= px;
        wr_y    <= py;
        wr_z    <= pz - ZW'(1);
        wr_data <= nd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fw_valid <= 1'b0;
      fw_data  <= '0;
    end else begin
      fw_valid <= hit;
      if (hit) fw_data <= nd;
    end
  end
endmodule

// File: rtl/disp_stencil_chk.sv
module disp_stencil_chk #(
  parameter int NX = 8,
  parameter int NY = 6,
  parameter int NZ = 5,
  parameter int W  = 32,
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ZW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           wr_valid,
  input logic [XW-1:0]  wr_x,
  input logic [YW-1:0]  wr_y,
  input logic [ZW-1:0]  wr_z,
  input logic [3*W-1:0] wr_data,
  input logic           fw_valid,
  input logic [3*W-1:0] fw_data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wr_valid && !fw_valid));

  // R2
  interior_xy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_x != '0 && int'(wr_x) <= NX - 2 && wr_y != '0 && int'(wr_y) <= NY - 2));

  // R8
  plane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_z != '0 && int'(wr_z) <= NZ - 2));

  // R7
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wr_valid);

  // R3
  raster_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid) && wr_y == $past(wr_y) && wr_z == $past(wr_z))
      |-> (wr_x == $past(wr_x) + XW'(1)));

  // R6
  twin_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid == fw_valid) && (!wr_valid || wr_data == fw_data));
endmodule

bind disp_stencil_update disp_stencil_chk #(
  .NX(NX), .NY(NY), .NZ(NZ), .W(W), .XW(XW), .YW(YW), .ZW(ZW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z), .wr_data(wr_data),
  .fw_valid(fw_valid), .fw_data(fw_data)
);

// File: tb/sim_disp_stencil_update.sv
module sim_disp_stencil_update;
  localparam int NX = 8, NY = 6, NZ = 5, W = 32, FRAC = 10, DT = 256;
  localparam int XW = $clog2(NX), YW = $clog2(NY), ZW = $clog2(NZ);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n, in_valid;
  logic [3*W-1:0] in_u, in_v, wr_data, fw_data;
  logic           wr_valid, fw_valid;
  logic [XW-1:0]  wr_x;
  logic [YW-1:0]  wr_y;
  logic [ZW-1:0]  wr_z;

  disp_stencil_update #(.NX(NX), .NY(NY), .NZ(NZ), .W(W), .FRAC(FRAC), .DT(DT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_u(in_u), .in_v(in_v),
    .wr_valid(wr_valid), .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z), .wr_data(wr_data),
    .fw_valid(fw_valid), .fw_data(fw_data));

  logic [W-1:0] tu [0:2][0:NZ-1][0:NY-1][0:NX-1];
  logic [W-1:0] tv [0:2][0:NZ-1][0:NY-1][0:NX-1];
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [W:0] half_diff(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] d;
    d = $signed({a[W-1], a}) - $signed({b[W-1], b});
    return d >>> 1;
  endfunction

  function automatic logic [W-1:0] model(input int c, input int x, input int y, input int z);
    logic signed [W:0] g [3];
    logic signed [127:0] adv, r, p, rd;
    g[0] = half_diff(tu[c][z][y][x+1], tu[c][z][y][x-1]);
    g[1] = half_diff(tu[c][z][y+1][x], tu[c][z][y-1][x]);
    g[2] = half_diff(tu[c][z+1][y][x], tu[c][z-1][y][x]);
    adv = '0;
    for (int k = 0; k < 3; k++)
      adv = adv + 128'($signed(tv[k][z][y][x])) * 128'(g[k]);
    r  = (128'($signed(tv[c][z][y][x])) <<< FRAC) - adv;
    p  = r * 128'(DT);
    rd = (p + (128'sd1 <<< (2 * FRAC - 1))) >>> (2 * FRAC);
    return W'(128'($signed(tu[c][z][y][x])) + rd);
  endfunction

  task automatic idle;
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(wr_valid == 1'b0, "R7", "valid after idle", 128'(wr_valid), 128'(0));
  endtask

  task automatic feed(input int x, input int y, input int z, input int tile, input string dreq);
    bit inner;
    logic [3*W-1:0] exp_d;
    in_valid = 1'b1;
    in_u = {tu[2][z][y][x], tu[1][z][y][x], tu[0][z][y][x]};
    in_v = {tv[2][z][y][x], tv[1][z][y][x], tv[0][z][y][x]};
    @(posedge clk); #1;
    inner = (z >= 2) && (x >= 1) && (x <= NX - 2) && (y >= 1) && (y <= NY - 2);
    if (z < 2 && tile > 0)
      chk(wr_valid == 1'b0, "R8", "valid in first planes of new tile", 128'(wr_valid), 128'(0));
    else
      chk(wr_valid == inner, "R2", "valid", 128'(wr_valid), 128'(inner));
    if (inner) begin
      chk(wr_x == XW'(x) && wr_y == YW'(y) && wr_z == ZW'(z - 1), "R3", "coords",
          128'({wr_z, wr_y, wr_x}), 128'({ZW'(z - 1), YW'(y), XW'(x)}));
      exp_d = {model(2, x, y, z - 1), model(1, x, y, z - 1), model(0, x, y, z - 1)};
      chk(wr_data == exp_d, dreq, "data (R9 packing)", 128'(wr_data), 128'(exp_d));
      chk(fw_valid && fw_data == wr_data, "R6", "forward copy", 128'(fw_data), 128'(wr_data));
    end
  endtask

  task automatic run_tile(input int tile, input int gap_pct, input string dreq, input int nvox);
    int n = 0;
    for (int z = 0; z < NZ; z++)
      for (int y = 0; y < NY; y++)
        for (int x = 0; x < NX; x++) begin
          if (n < nvox) begin
            if (int'($urandom % 100) < gap_pct) idle();
            feed(x, y, z, tile, dreq);
          end
          n++;
        end
    in_valid = 1'b0;
  endtask

  task automatic fill_random(input int span);
    for (int c = 0; c < 3; c++)
      for (int z = 0; z < NZ; z++)
        for (int y = 0; y < NY; y++)
          for (int x = 0; x < NX; x++) begin
            tu[c][z][y][x] = W'(int'($urandom % (2 * span)) - span);
            tv[c][z][y][x] = W'(int'($urandom % (2 * span)) - span);
          end
  endtask

  task automatic fill_directed;
    for (int z = 0; z < NZ; z++)
      for (int y = 0; y < NY; y++)
        for (int x = 0; x < NX; x++) begin
          tu[0][z][y][x] = W'(x * (x + 1) / 2 + 4 * y);
          tu[1][z][y][x] = W'(-(y * (y + 1) / 2) - 3 * x);
          tu[2][z][y][x] = W'(3 * (z * (z + 1) / 2) - x);
          if ((x + y + z) % 3 == 0) begin
            tv[0][z][y][x] = '0; tv[1][z][y][x] = '0; tv[2][z][y][x] = '0;
          end else begin
            tv[0][z][y][x] = W'((x - 3) * 1024);
            tv[1][z][y][x] = W'((y - 2) * 512);
            tv[2][z][y][x] = W'((1 - z) * 2048);
          end
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; in_u = '0; in_v = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!wr_valid && !fw_valid, "R1", "valids after reset", 128'({wr_valid, fw_valid}), 128'(0));

    fill_random(8192);
    run_tile(0, 0, "R5", 2 * NX * NY + 3 * NX);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk(!wr_valid && !fw_valid, "R1", "valids during reset", 128'({wr_valid, fw_valid}), 128'(0));
    rst_n = 1'b1;

    fill_random(8192);
    run_tile(0, 20, "R5", NX * NY * NZ);
    fill_directed();
    run_tile(1, 10, "R4", NX * NY * NZ);
    fill_random(1 << 20);
    run_tile(2, 0, "R5", NX * NY * NZ);
    idle();
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule